// File: doc/BRIEF.md
# GMII Receive Error Injector

This block sits in a loopback path, between a byte-wide transmit stream and the input of a receive MAC. It passes every byte through combinationally. While it is armed, it corrupts exactly one byte position of exactly one frame. A 16-bit fault mask, loaded by a single write strobe, says what is done to that byte. The low byte of the mask is XORed into the data. Mask bit 8 drops the frame-valid (enable) line for that one byte, so the receiver sees the frame break off early and discards it. Mask bit 9 raises the error line for that byte. These can be combined.

The faulted position is a byte offset counted from the first byte of the frame. A separate write changes it, and after reset it points into the payload, past a 14-byte header. Once the fault has been applied, the injector disarms itself and raises a sticky done flag. A data-only fault keeps the frame length and framing intact, so the receiver delivers the frame with a bad FCS. Test sequences use the block to confirm that the receiver counts CRC errors and discarded frames.

Top module: `gmii_err_inject`

## Requirements
- R1: After reset, `armed` and `done` are 0 and the byte offset is DEF_OFFSET (default 20).
- R2: While no injection is due, `outData`, `outEn` and `outErr` equal `inData`, `inEn` and `inErr` in the same cycle, with no register in the path.
- R3: A cycle with `armWr` high loads `armMask`. In the following cycle `armed` equals 1 if the mask is non-zero and 0 if it is zero, and `done` is 0.
- R4: In the faulted frame, at byte index equal to the offset, `outData` = `inData` XOR mask[7:0]. Byte index 0 is the first cycle with `inEn` high after a cycle with it low. All other bytes are unchanged, and with mask bits 9:8 clear the enable and error lines are unchanged.
- R5: With mask bit 8 set, `outEn` is 0 during the faulted byte only.
- R6: With mask bit 9 set, `outErr` is 1 during the faulted byte only.
- R7: The fault goes to the first frame whose first byte comes after the arming cycle. A frame already in progress, or one that starts in the arming cycle itself, passes through untouched.
- R8: In the cycle after the faulted byte, `done` is 1 and `armed` is 0. Later frames pass through untouched until the next arming write.
- R9: A cycle with `offWr` high loads `offVal` as the byte offset used for later frames.
- R10: A frame that ends before reaching the offset passes through untouched, and the injector stays armed for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Transmit-side data byte |
| inEn | input | 1 | Transmit-side frame-valid |
| inErr | input | 1 | Transmit-side error line |
| armWr | input | 1 | Arming write strobe |
| armMask | input | 16 | Fault mask loaded by `armWr` |
| offWr | input | 1 | Offset write strobe |
| offVal | input | 12 | Byte offset loaded by `offWr` |
| outData | output | 8 | Data byte to the receive MAC |
| outEn | output | 1 | Frame-valid to the receive MAC |
| outErr | output | 1 | Error line to the receive MAC |
| armed | output | 1 | Injector is waiting for a frame |
| done | output | 1 | Sticky: the fault has been applied |

## Verification
The assertions assume that frames are delimited only by `inEn`, so a frame starts on a rising edge of that line. They also assume that `armWr` and `offWr` are single-cycle strobes whose values are stable for the whole cycle. The stimulus always leaves at least two idle cycles between frames. It changes inputs only just after a rising clock edge, and it raises `armWr` at idle, in the first byte of a frame, and in the middle of a frame. This exercises both boundaries of the "next frame" rule.

// File: rtl/gmii_inj_pkg.sv
package gmii_inj_pkg;
  localparam int MASK_W  = 16;
  localparam int EN_BIT  = 8;
  localparam int ERR_BIT = 9;

  typedef struct packed {
    logic              hit;
    logic [MASK_W-1:0] mask;
  } injStrobe_t;
endpackage

// File: rtl/gmii_inj_ctrl.sv
module gmii_inj_ctrl
  import gmii_inj_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int DEF_OFFSET = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inEn,
  input  logic              armWr,
  input  logic [MASK_W-1:0] armMask,
  input  logic              offWr,
  input  logic [CNT_W-1:0]  offVal,
  output injStrobe_t        strobe,
  output logic              armed,
  output logic              done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OFF_RST = CNT_W'(DEF_OFFSET);

  logic              prevEn, armedQ, doneQ, activeQ;
  logic [MASK_W-1:0] maskQ;
  logic [CNT_W-1:0]  cntQ, offQ, byteIdx;
  logic              sof, activeNow, hit;

  assign sof       = inEn & ~prevEn;
  assign byteIdx   = sof ? '0 : cntQ;
  assign activeNow = sof ? armedQ : activeQ;
  assign hit       = activeNow & inEn & ~armWr & (byteIdx == offQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEn  <= 1'b0;
      cntQ    <= '0;
      offQ    <= OFF_RST;
      maskQ   <= '0;
      armedQ  <= 1'b0;
      doneQ   <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      prevEn <= inEn;
      if (inEn) cntQ <= (byteIdx == CNT_MAX) ? byteIdx : byteIdx + 1'b1;
      else      cntQ <= '0;
      if (offWr) offQ <= offVal;
      if (armWr) begin
        maskQ   <= armMask;
        armedQ  <= |armMask;
        doneQ   <= 1'b0;
        activeQ <= 1'b0;
      end else if (hit) begin
        armedQ  <= 1'b0;
        doneQ   <= 1'b1;
        activeQ <= 1'b0;
      end else if (!inEn) begin
        activeQ <= 1'b0;
      end else if (sof) begin
        activeQ <= armedQ;
      end
    end
  end

  assign strobe.hit  = hit;
  assign strobe.mask = maskQ;
  assign armed       = armedQ;
  assign done        = doneQ;

  // R8
  hit_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (doneQ && !armedQ));
  // R3
  arm_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    armWr |=> (!doneQ && (armedQ == $past(|armMask))));
  // R7
  hit_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (armedQ && inEn));
  // R8
  single_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !armWr) |-> !hit);
endmodule

// File: rtl/gmii_inj_dp.sv
module gmii_inj_dp
  import gmii_inj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEn,
  input  logic              inErr,
  output logic [DATA_W-1:0] outData,
  output logic              outEn,
  output logic              outErr
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_flip
    assign outData[b] = inData[b] ^ (strobe.hit & strobe.mask[b]);
  end
  assign outEn  = inEn  & ~(strobe.hit & strobe.mask[EN_BIT]);
  assign outErr = inErr |  (strobe.hit & strobe.mask[ERR_BIT]);

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hit |-> (outData == inData && outEn == inEn && outErr == inErr));
  // R5
  en_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hit && strobe.mask[EN_BIT]) |-> !outEn);
  // R6
  err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hit && strobe.mask[ERR_BIT]) |-> outErr);
endmodule

// File: rtl/gmii_err_inject.sv
module gmii_err_inject
  import gmii_inj_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 12,
  parameter int DEF_OFFSET = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEn,
  input  logic              inErr,
  input  logic              armWr,
  input  logic [MASK_W-1:0] armMask,
  input  logic              offWr,
  input  logic [CNT_W-1:0]  offVal,
  output logic [DATA_W-1:0] outData,
  output logic              outEn,
  output logic              outErr,
  output logic              armed,
  output logic              done
);
  injStrobe_t strobe;

  gmii_inj_ctrl #(.CNT_W(CNT_W), .DEF_OFFSET(DEF_OFFSET)) u_ctrl (
    .clk(clk), .rstN(rstN), .inEn(inEn), .armWr(armWr), .armMask(armMask),
    .offWr(offWr), .offVal(offVal), .strobe(strobe), .armed(armed), .done(done)
  );

  gmii_inj_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inEn(inEn),
    .inErr(inErr), .outData(outData), .outEn(outEn), .outErr(outErr)
  );
endmodule

// File: tb/sim_gmii_err_inject.sv
module sim_gmii_err_inject;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] d;
    logic       en;
    logic       er;
    string      req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inEn = 1'b0, inErr = 1'b0, armWr = 1'b0, offWr = 1'b0;
  logic [15:0] armMask = '0;
  logic [11:0] offVal = '0;
  logic [7:0]  outData;
  logic        outEn, outErr, armed, done;

  int checks = 0;
  int errors = 0;
  expItem_t q[$];

  gmii_err_inject u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inEn(inEn), .inErr(inErr),
    .armWr(armWr), .armMask(armMask), .offWr(offWr), .offVal(offVal),
    .outData(outData), .outEn(outEn), .outErr(outErr), .armed(armed), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle, compares at negedge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      check(outData == e.d, e.req, outData, e.d);
      check(outEn == e.en, e.req, outEn, e.en);
      check(outErr == e.er, e.req, outErr, e.er);
    end
  end

  task automatic push(input logic [7:0] d, input logic en, input logic er, input string req);
    expItem_t e;
    e.d = d; e.en = en; e.er = er; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inData = '0; inEn = 1'b0; inErr = 1'b0; armWr = 1'b0; offWr = 1'b0;
      push(8'h00, 1'b0, 1'b0, req);
    end
  endtask

  // injOff < 0: no fault expected; armAt >= 0: arming write on that byte
  task automatic frame(input int len, input int injOff, input logic [15:0] m,
                       input int armAt, input logic [15:0] newMask, input string req);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'((i * 7 + 3) & 8'hff);
      @(posedge clk); #1;
      inData = d; inEn = 1'b1; inErr = 1'b0; offWr = 1'b0;
      armWr = (i == armAt); armMask = newMask;
      if (i == injOff) push(d ^ m[7:0], ~m[8], m[9], req);
      else             push(d, 1'b1, 1'b0, req);
    end
    idle(2, req);
  endtask

  task automatic arm(input logic [15:0] m);
    @(posedge clk); #1;
    armWr = 1'b1; armMask = m; inEn = 1'b0; inData = '0;
    push(8'h00, 1'b0, 1'b0, "R2");
    idle(1, "R2");
  endtask

  task automatic setOff(input int o);
    @(posedge clk); #1;
    offWr = 1'b1; offVal = 12'(o);
    push(8'h00, 1'b0, 1'b0, "R9");
    idle(1, "R9");
  endtask

  task automatic flags(input logic a, input logic dn, input string req);
    @(negedge clk);
    check(armed == a, req, armed, a);
    check(done == dn, req, done, dn);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1
    flags(1'b0, 1'b0, "R1");
    // R2: disarmed frame untouched
    frame(30, -1, 16'h0, -1, 16'h0, "R2");
    // R3, R4 (default offset 20), R8
    arm(16'h0001);
    flags(1'b1, 1'b0, "R3");
    frame(64, 20, 16'h0001, -1, 16'h0, "R4");
    flags(1'b0, 1'b1, "R8");
    frame(64, -1, 16'h0, -1, 16'h0, "R8");
    arm(16'h0080);
    frame(40, 20, 16'h0080, -1, 16'h0, "R4");
    // R9, R5
    setOff(5);
    arm(16'h0100);
    frame(30, 5, 16'h0100, -1, 16'h0, "R5");
    flags(1'b0, 1'b1, "R5");
    // R6
    arm(16'h0200);
    frame(30, 5, 16'h0200, -1, 16'h0, "R6");
    // R7: arming mid-frame leaves the current frame alone
    frame(30, -1, 16'h0, 3, 16'h0004, "R7");
    flags(1'b1, 1'b0, "R7");
    frame(30, 5, 16'h0004, -1, 16'h0, "R7");
    // R7: arming in the first byte of a frame
    frame(30, -1, 16'h0, 0, 16'h0302, "R7");
    frame(30, 5, 16'h0302, -1, 16'h0, "R7");
    // R10: short frame leaves the injector armed
    setOff(40);
    arm(16'h0010);
    frame(20, -1, 16'h0, -1, 16'h0, "R10");
    flags(1'b1, 1'b0, "R10");
    frame(60, 40, 16'h0010, -1, 16'h0, "R10");
    flags(1'b0, 1'b1, "R10");
    // R3: zero-mask write clears done and stays disarmed
    arm(16'h0000);
    flags(1'b0, 1'b0, "R3");
    frame(60, -1, 16'h0, -1, 16'h0, "R3");
    idle(2, "R2");
    @(negedge clk); #1;
    check(q.size() == 0, "R2", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule